// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block is a synchronous state machine that decides the power state of a memory and bus bridge controller. It produces one enable for each functional group it governs: inbound address decode, memory refresh, processor request monitoring and the core units. It also drives a global signal that sends the bridge's outputs to high impedance. Software asks for a low-power state by writing a two-bit mode register while the bridge runs at full power. An external suspend pin forces the deepest state at any time. The wake sources are a processor bus request, an inbound transaction that hits system memory, and hard reset.

Where a wake from doze or nap leads depends on its source. A doze wake from either source, and a nap wake from an inbound access, pass through a serving state. When `access_done` marks the end of the access, the block falls back to the low-power state it came from. A processor request during nap or sleep clears the mode register, so the bridge stays at full power. Leaving sleep also waits for the clock generator to report lock, and the request is held pending until then. The PLL, the clock gating, refresh timing and the bus protocols sit outside the block and appear only as handshake inputs.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `hrst` is high and `susp_pin` is low, the block goes to full power (state code 0) at the next clock and clears the mode register to 00. At full power all four enables are 1 and `out_hiz` is 0.
- R2: The mode register is written from `mode_wdata` when `mode_wr` is high in full power. The encodings are 00 full, 01 doze, 10 nap and 11 sleep. One clock after the register update, value 01 moves the state to doze (code 1), and 00 keeps it at full power.
- R3: Nap (code 2) and sleep (code 3) are entered from full power only when `cpu_pd_ack` is high. Otherwise the block stays at full power.
- R4: The registered outputs `{en_addr_decode,en_refresh,en_req_monitor,en_core,out_hiz}` follow the state. Full power and serving give 11110. Doze and nap give 11100. Sleep gives 0,`cfg_sleep_refresh`,0,0,0. Suspend gives 01001.
- R5: In doze, a `cpu_bus_req` or `mem_hit` moves the block to the serving state (code 5) at the next clock. `access_done` then returns it to doze.
- R6: In nap, a `mem_hit` leads to serving and then, on `access_done`, back to nap. A `cpu_bus_req` moves the block to full power and clears the mode register. The processor request wins if both are present.
- R7: In sleep, `mem_hit` is ignored. A `cpu_bus_req` is held pending, and the block moves to full power, clearing the mode register, only in a cycle where `pll_locked` is high.
- R8: A hard reset wakes the block from any low-power state to full power.
- R9: A high `susp_pin` moves the block to suspend (code 4) at the next clock from any state. While the pin stays high, all other inputs, `hrst` included, are ignored and the mode register keeps its value.
- R10: When `susp_pin` falls, the block goes to full power with the mode register cleared, so it stays at full power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hrst | input | 1 | Hard reset, synchronous, active high, ignored during suspend |
| susp_pin | input | 1 | External suspend request |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Mode value to write |
| cfg_sleep_refresh | input | 1 | Keep refresh enabled during sleep |
| cpu_pd_ack | input | 1 | Processor acknowledges power-down |
| cpu_bus_req | input | 1 | Processor bus request (wake source) |
| mem_hit | input | 1 | Inbound transaction targets system memory |
| access_done | input | 1 | End of the access that caused a wake |
| pll_locked | input | 1 | Clock generator is locked |
| en_addr_decode | output | 1 | Inbound address decode enable |
| en_refresh | output | 1 | Memory refresh enable |
| en_req_monitor | output | 1 | Processor request monitor enable |
| en_core | output | 1 | Core functional units enable |
| out_hiz | output | 1 | Release outputs to high impedance |
| state_code | output | 3 | Current state encoding |

## Verification
On every cycle, the assertions check the local transition rules. These are: no nap or sleep entry without acknowledge, doze wakes leading to serving, a processor request in nap leading to full power, sleep holding while the clock is unlocked and ignoring memory hits, suspend taking over from any state while the mode register holds, and the output pattern during suspend. Other behaviours span several transitions, and only the bench's scenarios can show them. These include the state a serving pass returns to, whether the mode register was really cleared so the block does not drop back into a low-power state, a processor request pending until lock, and reset being ignored under suspend. The bench sweeps every mode, acknowledge level, wake source and refresh setting against a state table computed inside the bench.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int MODE_W  = 2;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    PS_FULL  = 3'd0,
    PS_DOZE  = 3'd1,
    PS_NAP   = 3'd2,
    PS_SLEEP = 3'd3,
    PS_SUSP  = 3'd4,
    PS_SERVE = 3'd5
  } pwr_state_e;

  localparam logic [MODE_W-1:0] MODE_FULL  = 2'b00;
  localparam logic [MODE_W-1:0] MODE_DOZE  = 2'b01;
  localparam logic [MODE_W-1:0] MODE_NAP   = 2'b10;
  localparam logic [MODE_W-1:0] MODE_SLEEP = 2'b11;
endpackage

// File: rtl/pwr_mode_reg.sv
module pwr_mode_reg #(
  parameter int W = pwr_seq_pkg::MODE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         susp,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         accept,
  input  logic         clr,
  output logic [W-1:0] mode_q
);
  always_ff @(posedge clk) begin
    if (rst)                 mode_q <= '0;
    else if (susp)           mode_q <= mode_q;
    else if (clr)            mode_q <= '0;
    else if (wr_en && accept) mode_q <= wr_data;
  end

  // The register is frozen while suspend holds
  assert_susp_mode_hold_R9: assert property (@(posedge clk) disable iff (rst)
    susp |=> $stable(mode_q));
endmodule

// File: rtl/pwr_wake_pend.sv
module pwr_wake_pend (
  input  logic clk,
  input  logic rst,
  input  logic in_sleep,
  input  logic req,
  output logic pend_q
);
  always_ff @(posedge clk) begin
    if (rst || !in_sleep) pend_q <= 1'b0;
    else if (req)         pend_q <= 1'b1;
  end
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              susp,
  input  logic [MODE_W-1:0] mode_q,
  input  logic              cpu_pd_ack,
  input  logic              cpu_req,
  input  logic              mem_hit,
  input  logic              access_done,
  input  logic              pll_locked,
  input  logic              pend_q,
  output pwr_state_e        state_q,
  output pwr_state_e        state_d,
  output logic              mode_clr
);
  logic ret_nap_q, ret_nap_d;
  logic wake_go;

  assign wake_go = (cpu_req || pend_q) && pll_locked;

  always_comb begin
    state_d   = state_q;
    ret_nap_d = ret_nap_q;
    mode_clr  = 1'b0;
    if (susp) begin
      state_d = PS_SUSP;
    end else begin
      case (state_q)
        PS_FULL: begin
          case (mode_q)
            MODE_DOZE:  state_d = PS_DOZE;
            MODE_NAP:   if (cpu_pd_ack) state_d = PS_NAP;
            MODE_SLEEP: if (cpu_pd_ack) state_d = PS_SLEEP;
            default:    state_d = PS_FULL;
          endcase
        end
        PS_DOZE: begin
          if (cpu_req || mem_hit) begin
            state_d   = PS_SERVE;
            ret_nap_d = 1'b0;
          end
        end
        PS_NAP: begin
          if (cpu_req) begin
            state_d  = PS_FULL;
            mode_clr = 1'b1;
          end else if (mem_hit) begin
            state_d   = PS_SERVE;
            ret_nap_d = 1'b1;
          end
        end
        PS_SLEEP: begin
          if (wake_go) begin
            state_d  = PS_FULL;
            mode_clr = 1'b1;
          end
        end
        PS_SERVE: begin
          if (access_done) state_d = ret_nap_q ? PS_NAP : PS_DOZE;
        end
        PS_SUSP: begin
          state_d  = PS_FULL;
          mode_clr = 1'b1;
        end
        default: state_d = PS_FULL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= PS_FULL;
      ret_nap_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      ret_nap_q <= ret_nap_d;
    end
  end

  assert_lowpwr_needs_ack_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_FULL && !cpu_pd_ack && !susp) |=>
      (state_q != PS_NAP && state_q != PS_SLEEP));

  assert_doze_wake_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_DOZE && (cpu_req || mem_hit) && !susp) |=> state_q == PS_SERVE);

  assert_nap_cpu_full_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_NAP && cpu_req && !susp) |=> state_q == PS_FULL);

  assert_sleep_lock_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_SLEEP && !pll_locked && !susp) |=> state_q == PS_SLEEP);

  assert_sleep_no_hit_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_SLEEP && !susp) |=> (state_q != PS_SERVE));

  assert_susp_entry_R9: assert property (@(posedge clk) disable iff (rst)
    susp |=> state_q == PS_SUSP);
endmodule

// File: rtl/pwr_out_dec.sv
module pwr_out_dec
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_sleep_refresh,
  input  pwr_state_e state_d,
  output logic       en_addr_decode,
  output logic       en_refresh,
  output logic       en_req_monitor,
  output logic       en_core,
  output logic       out_hiz
);
  logic [4:0] pat;

  always_comb begin
    case (state_d)
      PS_FULL, PS_SERVE: pat = 5'b11110;
      PS_DOZE, PS_NAP:   pat = 5'b11100;
      PS_SLEEP:          pat = {1'b0, cfg_sleep_refresh, 3'b000};
      PS_SUSP:           pat = 5'b01001;
      default:           pat = 5'b11110;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) {en_addr_decode, en_refresh, en_req_monitor, en_core, out_hiz} <= 5'b11110;
    else     {en_addr_decode, en_refresh, en_req_monitor, en_core, out_hiz} <= pat;
  end

  assert_hiz_pattern_R9: assert property (@(posedge clk) disable iff (rst)
    out_hiz |-> (en_refresh && !en_core && !en_addr_decode && !en_req_monitor));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic                        clk,
  input  logic                        hrst,
  input  logic                        susp_pin,
  input  logic                        mode_wr,
  input  logic [pwr_seq_pkg::MODE_W-1:0] mode_wdata,
  input  logic                        cfg_sleep_refresh,
  input  logic                        cpu_pd_ack,
  input  logic                        cpu_bus_req,
  input  logic                        mem_hit,
  input  logic                        access_done,
  input  logic                        pll_locked,
  output logic                        en_addr_decode,
  output logic                        en_refresh,
  output logic                        en_req_monitor,
  output logic                        en_core,
  output logic                        out_hiz,
  output logic [pwr_seq_pkg::STATE_W-1:0] state_code
);
  logic              eff_rst;
  logic [MODE_W-1:0] mode_q;
  logic              mode_clr;
  logic              pend_q;
  pwr_state_e        state_q, state_d;

  // Suspend masks the hard reset
  assign eff_rst = hrst && !susp_pin;

  pwr_mode_reg #(.W(MODE_W)) u_mode (
    .clk(clk), .rst(eff_rst), .susp(susp_pin), .wr_en(mode_wr),
    .wr_data(mode_wdata), .accept(state_q == PS_FULL), .clr(mode_clr),
    .mode_q(mode_q)
  );

  pwr_wake_pend u_pend (
    .clk(clk), .rst(eff_rst), .in_sleep(state_q == PS_SLEEP),
    .req(cpu_bus_req), .pend_q(pend_q)
  );

  pwr_fsm u_fsm (
    .clk(clk), .rst(eff_rst), .susp(susp_pin), .mode_q(mode_q),
    .cpu_pd_ack(cpu_pd_ack), .cpu_req(cpu_bus_req), .mem_hit(mem_hit),
    .access_done(access_done), .pll_locked(pll_locked), .pend_q(pend_q),
    .state_q(state_q), .state_d(state_d), .mode_clr(mode_clr)
  );

  pwr_out_dec u_out (
    .clk(clk), .rst(eff_rst), .cfg_sleep_refresh(cfg_sleep_refresh),
    .state_d(state_d), .en_addr_decode(en_addr_decode), .en_refresh(en_refresh),
    .en_req_monitor(en_req_monitor), .en_core(en_core), .out_hiz(out_hiz)
  );

  assign state_code = state_q;
endmodule

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;
  logic clk = 1'b0;
  logic hrst = 1'b1, susp_pin = 1'b0, mode_wr = 1'b0;
  logic [1:0] mode_wdata = 2'b00;
  logic cfg_sleep_refresh = 1'b0, cpu_pd_ack = 1'b0, cpu_bus_req = 1'b0;
  logic mem_hit = 1'b0, access_done = 1'b0, pll_locked = 1'b1;
  logic en_addr_decode, en_refresh, en_req_monitor, en_core, out_hiz;
  logic [2:0] state_code;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwr_seq_ctrl uut (
    .clk(clk), .hrst(hrst), .susp_pin(susp_pin), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .cfg_sleep_refresh(cfg_sleep_refresh),
    .cpu_pd_ack(cpu_pd_ack), .cpu_bus_req(cpu_bus_req), .mem_hit(mem_hit),
    .access_done(access_done), .pll_locked(pll_locked),
    .en_addr_decode(en_addr_decode), .en_refresh(en_refresh),
    .en_req_monitor(en_req_monitor), .en_core(en_core), .out_hiz(out_hiz),
    .state_code(state_code)
  );

  function automatic int exp_out(int st, bit cfg);
    case (st)
      0, 5:    return 5'b11110;
      1, 2:    return 5'b11100;
      3:       return {1'b0, cfg, 3'b000};
      4:       return 5'b01001;
      default: return 5'b11110;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_st(string tag, int exp_st);
    chk({tag, " state"}, int'(state_code), exp_st);
    chk({tag, " outputs R4"},
        int'({en_addr_decode, en_refresh, en_req_monitor, en_core, out_hiz}),
        exp_out(exp_st, cfg_sleep_refresh));
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    hrst = 1'b1;
    tick(2);
    hrst = 1'b0;
  endtask

  task automatic write_mode(logic [1:0] m);
    mode_wr = 1'b1;
    mode_wdata = m;
    tick();
    mode_wr = 1'b0;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(2);
    hrst = 1'b0;
    chk_st("R1 reset", 0);

    // Sweep over refresh config, mode value, acknowledge and wake source
    for (int cfg = 0; cfg < 2; cfg++) begin
      for (int m = 0; m < 4; m++) begin
        for (int ack = 0; ack < 2; ack++) begin
          for (int src = 0; src < 3; src++) begin
            int entry, a2, a3;
            do_reset();
            cfg_sleep_refresh = cfg[0];
            cpu_pd_ack = ack[0];
            pll_locked = 1'b1;
            write_mode(m[1:0]);
            entry = (m == 0) ? 0 : (m == 1) ? 1 : (ack != 0) ? ((m == 2) ? 2 : 3) : 0;
            chk_st("R2 R3 entry", entry);
            tick();
            chk_st("R2 R3 hold", entry);
            case (entry)
              1:       a2 = (src != 0) ? 5 : 1;
              2:       a2 = (src == 1) ? 0 : (src == 2) ? 5 : 2;
              3:       a2 = (src == 1) ? 0 : 3;
              default: a2 = 0;
            endcase
            cpu_bus_req = (src == 1);
            mem_hit = (src == 2);
            tick();
            cpu_bus_req = 1'b0;
            mem_hit = 1'b0;
            chk_st("R5 R6 R7 wake", a2);
            a3 = (a2 == 5) ? entry : a2;
            access_done = 1'b1;
            tick();
            access_done = 1'b0;
            chk_st("R5 R6 return", a3);
            tick(2);
            chk_st("R6 R7 settle", a3);
          end
        end
      end
    end

    // R6: both sources in nap, processor wins
    do_reset();
    cpu_pd_ack = 1'b1;
    write_mode(2'b10);
    chk_st("R6 nap", 2);
    cpu_bus_req = 1'b1; mem_hit = 1'b1;
    tick();
    cpu_bus_req = 1'b0; mem_hit = 1'b0;
    chk_st("R6 cpu priority", 0);
    tick(2);
    chk_st("R6 stays full", 0);

    // R7: request pending until lock
    do_reset();
    cfg_sleep_refresh = 1'b1;
    pll_locked = 1'b0;
    write_mode(2'b11);
    chk_st("R7 sleep", 3);
    cpu_bus_req = 1'b1;
    tick();
    cpu_bus_req = 1'b0;
    chk_st("R7 unlocked hold", 3);
    tick(3);
    chk_st("R7 still pending", 3);
    pll_locked = 1'b1;
    tick();
    chk_st("R7 locked wake", 0);
    tick(2);
    chk_st("R7 mode cleared", 0);

    // R8: hard reset out of nap and doze
    do_reset();
    write_mode(2'b10);
    chk_st("R8 nap", 2);
    hrst = 1'b1;
    tick();
    hrst = 1'b0;
    chk_st("R8 reset wake", 0);
    tick(2);
    chk_st("R8 stays full", 0);
    write_mode(2'b01);
    chk_st("R8 doze", 1);
    hrst = 1'b1;
    tick();
    hrst = 1'b0;
    chk_st("R8 reset from doze", 0);

    // R9 and R10: suspend overrides everything
    write_mode(2'b01);
    chk_st("R9 doze before", 1);
    susp_pin = 1'b1; hrst = 1'b1; mem_hit = 1'b1; cpu_bus_req = 1'b1;
    tick();
    chk_st("R9 suspend", 4);
    tick(2);
    chk_st("R9 reset ignored", 4);
    hrst = 1'b0; mem_hit = 1'b0; cpu_bus_req = 1'b0;
    tick();
    chk_st("R9 still suspend", 4);
    susp_pin = 1'b0;
    tick();
    chk_st("R10 exit full", 0);
    tick(2);
    chk_st("R10 mode cleared", 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule